// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block times the two half-periods of the SCL clock of an I2C master. A controller above it asks for SCL to be pulled low or let go, and gives a 7-bit half-period length. The block counts that length down on a tick that fires once every four system clocks. When the count reaches zero it pulses a strobe. The controller then issues its next request. The counter stops at zero and stays there until a new request arrives.

Pulling SCL low starts the count at once. Letting SCL go works differently. The block stops driving the line, then waits until its synchronized copy of the pin reads high before it starts counting. A slave that holds SCL low therefore stretches the phase for as long as it holds the line. The high half-period is measured from the moment SCL is really high. While the enable is low, the block leaves the line alone, does not count, and pays no attention to requests or to the pin.

Top module: `i2c_scl_clkgen`

## Requirements
- R1: After reset, `scl_drive_low`, `busy` and `half_done` are all 0.
- R2: A request with `req_high`=0 sets `scl_drive_low` and `busy` one cycle later. The length N is taken as `reload`, or as 1 when `reload` is 0. Exactly 4*N cycles after the request edge, `busy` falls and `half_done` pulses for one cycle. So `busy` is high for 4*N consecutive cycles.
- R3: A request with `req_high`=1 clears `scl_drive_low` and sets `busy` one cycle later. Counting starts only on the third clock edge after the SCL pin is first seen high. If the pin rises after the k-th edge that follows the request edge, `busy` is high for k+3+4*N cycles. While the pin stays low, `busy` stays high and `half_done` stays low.
- R4: Once the count has expired, `half_done` is low on the next cycle. `busy` stays low and no further `half_done` appears until a new request arrives.
- R5: A `reload` value of 0 gives the same timing as a value of 1, which is 4 cycles.
- R6: While `en` is 0, the block releases SCL, clears `busy` and clears the count by the next cycle. Requests and the pin level are ignored: `scl_drive_low`, `busy` and `half_done` stay 0. Raising `en` again does not start a count by itself.
- R7: A request that arrives while `busy` is high restarts the count from the new length. The earlier count produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable |
| reload | input | 7 | Half-period length, counted in quarter-rate ticks |
| req_valid | input | 1 | One-cycle request strobe |
| req_high | input | 1 | Request kind: 1 lets SCL go high, 0 pulls it low |
| scl_in | input | 1 | Level read back from the SCL pin (asynchronous) |
| scl_drive_low | output | 1 | Open-drain enable: 1 pulls SCL low |
| half_done | output | 1 | One-cycle strobe when the half-period expires |
| busy | output | 1 | High while a half-period is waiting or counting |

## Verification
The hardest case to reach is a stretched high phase. The release has taken effect, but the pin is still low, so the count has not started. The bench models the wire as low whenever the block or a simulated slave pulls it. It releases the slave a chosen number of edges k after the release request, sweeping k together with the length. The expected busy time, k+3+4N, is computed from that number alone. Low phases are swept over every length from 0 to 127.

// File: rtl/i2c_scl_clkgen.sv
module i2c_scl_clkgen #(
  parameter int RW = 7,
  parameter int PRESCALE = 4,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [RW-1:0] reload,
  input  logic          req_valid,
  input  logic          req_high,
  input  logic          scl_in,
  output logic          scl_drive_low,
  output logic          half_done,
  output logic          busy
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);

  logic [SYNC-1:0] sync_q;
  logic [PW-1:0]   pre;
  logic [RW-1:0]   cnt;
  logic            waiting;

  wire             scl_s = sync_q[SYNC-1];
  wire             tick  = (pre == PRE_LAST);
  wire [RW-1:0]    eff   = (reload == '0) ? RW'(1) : reload;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC-2:0], scl_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_drive_low <= 1'b0;
      half_done     <= 1'b0;
      busy          <= 1'b0;
      waiting       <= 1'b0;
      cnt           <= '0;
      pre           <= '0;
    end else if (!en) begin
      scl_drive_low <= 1'b0;
      half_done     <= 1'b0;
      busy          <= 1'b0;
      waiting       <= 1'b0;
      cnt           <= '0;
      pre           <= '0;
    end else begin
      half_done <= 1'b0;
      if (req_valid) begin
        busy <= 1'b1;
        if (req_high) begin
          scl_drive_low <= 1'b0;
          waiting       <= 1'b1;
        end else begin
          scl_drive_low <= 1'b1;
          waiting       <= 1'b0;
          cnt           <= eff;
          pre           <= '0;
        end
      end else if (waiting) begin
        if (scl_s) begin
          waiting <= 1'b0;
          cnt     <= eff;
          pre     <= '0;
        end
      end else if (busy) begin
        pre <= tick ? '0 : pre + PW'(1);
        if (tick) begin
          cnt <= cnt - RW'(1);
          if (cnt == RW'(1)) begin
            busy      <= 1'b0;
            half_done <= 1'b1;
          end
        end
      end
    end
  end

  // R2
  low_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && req_valid && !req_high |=> scl_drive_low && busy);
  // R3
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && waiting && !scl_s && !req_valid |=> busy && !half_done && waiting);
  // R4
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half_done |-> !busy);
  // R4
  strobe_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half_done |=> !half_done);
  // R2
  fall_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && $past(en) |-> half_done);
  // R6
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy && !scl_drive_low && !half_done);
endmodule

// File: tb/tb_i2c_scl_clkgen.sv
`timescale 1ns/1ps
module tb_i2c_scl_clkgen;
  logic clk = 0, rst_n = 0, en = 0, req_valid = 0, req_high = 0, stretch = 1;
  logic [6:0] reload = 0;
  logic scl_drive_low, half_done, busy, scl_in;
  int checks = 0, errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  assign scl_in = ~(scl_drive_low | stretch);

  i2c_scl_clkgen dut (.clk(clk), .rst_n(rst_n), .en(en), .reload(reload),
    .req_valid(req_valid), .req_high(req_high), .scl_in(scl_in),
    .scl_drive_low(scl_drive_low), .half_done(half_done), .busy(busy));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic request(input int n, input logic hi);
    @(negedge clk);
    reload = n[6:0]; req_high = hi; req_valid = 1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic count_busy(input int k, output int cnt, output int strobe);
    cnt = 0; strobe = 0;
    for (int j = 0; busy && j < 3000; j++) begin
      if (j == k) stretch = 0;
      if (half_done) strobe++;
      cnt++;
      @(negedge clk);
    end
  endtask

  task automatic do_low(input int n);
    int c, s, e;
    e = (n == 0) ? 1 : n;
    request(n, 0);
    chk("R2 drive", scl_drive_low, 1);
    count_busy(-1, c, s);
    chk(n == 0 ? "R5 length" : "R2 length", c, 4 * e);
    chk("R2 strobe", half_done, 1);
    chk("R2 early strobe", s, 0);
    @(negedge clk);
    chk("R4 strobe low", half_done, 0);
  endtask

  task automatic do_rel(input int n, input int k);
    int c, s, e;
    e = (n == 0) ? 1 : n;
    stretch = 1;
    request(n, 1);
    chk("R3 release", scl_drive_low, 0);
    count_busy(k, c, s);
    chk("R3 length", c, k + 3 + 4 * e);
    chk("R3 no early strobe", s, 0);
    chk("R3 strobe", half_done, 1);
  endtask

  initial begin
    #1;
    chk("R1 drive", scl_drive_low, 0);
    chk("R1 busy", busy, 0);
    chk("R1 strobe", half_done, 0);
    #10 rst_n = 1; en = 1;
    @(negedge clk);
    chk("R1 idle", busy, 0);

    for (int n = 0; n < 128; n++) do_low(n);

    for (int n = 0; n < 6; n++)
      for (int k = 0; k < 7; k++) begin
        do_low(2);
        do_rel(n, k);
      end
    do_low(1);
    do_rel(40, 25);

    // R4: no automatic reload after expiry
    begin
      int s = 0, b = 0;
      for (int j = 0; j < 60; j++) begin
        @(negedge clk);
        s += half_done; b += busy;
      end
      chk("R4 no reload strobe", s, 0);
      chk("R4 no reload busy", b, 0);
    end

    // R7: restart while busy
    begin
      int c, s;
      request(10, 0);
      repeat (7) @(negedge clk);
      request(3, 0);
      count_busy(-1, c, s);
      chk("R7 restart length", c, 12);
      chk("R7 no old strobe", s, 0);
    end

    // R6: disable mid-count and ignore inputs
    begin
      int s = 0, b = 0, d = 0;
      request(20, 0);
      repeat (5) @(negedge clk);
      en = 0;
      @(negedge clk);
      chk("R6 busy cleared", busy, 0);
      chk("R6 released", scl_drive_low, 0);
      req_high = 0; reload = 5; req_valid = 1;
      for (int j = 0; j < 30; j++) begin
        stretch = j[0];
        @(negedge clk);
        s += half_done; b += busy; d += scl_drive_low;
      end
      req_valid = 0;
      en = 1;
      for (int j = 0; j < 20; j++) begin
        @(negedge clk);
        s += half_done; b += busy; d += scl_drive_low;
      end
      chk("R6 no strobe", s, 0);
      chk("R6 no busy", b, 0);
      chk("R6 no drive", d, 0);
      do_low(4);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog: actual %0d expected below %0d", cycles, 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule